// File: doc/BRIEF.md
# Parameterized Stream Link with Signal Path

This block joins one producer process to one consumer process on a single clock. The producer offers a word with a data bus and an offer strobe and sees a ready line. The consumer sees an availability strobe with the data and answers with its own ready line. A word moves on a rising edge when offer and ready are both high on that side. Words are never duplicated or dropped, and they keep their order.

An elaboration parameter chooses how the words travel. In tag mode, one registered slot with a valid tag sits between the two sides. In queue mode, a small first-in first-out buffer of parameter depth decouples them. The payload width is a parameter.

A second path, separate from the data stream, carries post and wait events. A post that no wait takes at once is held pending, together with an optional payload, until a wait takes it. A post and a wait in the same cycle pass the payload straight through. A poster that finds an event already pending is stalled.

Top module: `stream_link`

## Requirements
- R1: A synchronous reset empties the link. In the cycle after reset, `rd_avail` is 0, `wr_ready` is 1, `post_done` is 1 for a request, and a `wait_req` gets `wait_done` 0 because nothing is pending.
- R2: A word enters on a rising edge where `wr_valid` and `wr_ready` are both 1. It leaves on an edge where `rd_avail` and `rd_ready` are both 1. Words leave in the order they entered, each exactly once.
- R3: In queue mode (`MODE` = LINK_FIFO, encoded 1), `wr_ready` is 0 exactly while DEPTH words are held.
- R4: In queue mode, `rd_avail` is 1 whenever at least one word is held. A word written into an empty queue is visible on `rd_data` in the cycle right after its write edge, and not before that edge.
- R5: In tag mode (`MODE` = LINK_TAG, encoded 0), while `rd_avail` is 1 and `rd_ready` is 0, `rd_avail` and `rd_data` hold their values into the next cycle.
- R6: In tag mode, `wr_ready` equals `!rd_avail || rd_ready`. The slot can take a new word on the same edge that the old one leaves.
- R7: When nothing is pending, `post_done` equals `post_req`. A post that no wait takes in that cycle becomes pending. A later `wait_req` then gets `wait_done` 1 with the posted payload on `wait_data`, and this clears the pending event.
- R8: When nothing is pending and `post_req` and `wait_req` are both 1, both done strobes are 1 in that cycle. `wait_data` then equals `post_data`, and nothing is left pending afterwards.
- R9: While an event is pending, `post_done` is 0 and the held payload is not overwritten by further posts.
- R10: With `HAS_PAYLOAD` = 0, no payload is stored and `wait_data` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| wr_data | input | DATA_W | Producer word |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | Link can take a word this cycle |
| rd_data | output | DATA_W | Word presented to the consumer |
| rd_avail | output | 1 | `rd_data` holds a word |
| rd_ready | input | 1 | Consumer takes the presented word |
| post_req | input | 1 | Post an event |
| post_data | input | SIG_W | Payload of the event |
| post_done | output | 1 | Post accepted this cycle |
| wait_req | input | 1 | Wait for an event |
| wait_done | output | 1 | Wait satisfied this cycle |
| wait_data | output | SIG_W | Payload delivered with `wait_done` |

## Verification
The link outputs are registered, so a word accepted on an edge shows up on `rd_avail` and `rd_data` one cycle later, whatever the mode. The event path answers combinationally in the cycle of its request, and a pending event becomes visible one edge after its post. The bench drives inputs just after the falling edge. It reads the done strobes one nanosecond after driving and samples the stream handshakes two nanoseconds before the rising edge, so each result is compared in exactly the cycle where it is due. A scoreboard queue records every accepted word and matches it against every word the consumer takes.

// File: rtl/stream_link_pkg.sv
package stream_link_pkg;

   typedef enum logic {
      LINK_TAG  = 1'b0,
      LINK_FIFO = 1'b1
   } link_mode_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/stream_tag_slot.sv
module stream_tag_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_vld,
   output logic              in_rdy,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld,
   input  logic              out_rdy
);

   logic              tag_q;
   logic [DATA_W-1:0] word_q;

   assign in_rdy   = !tag_q || out_rdy;
   assign out_vld  = tag_q;
   assign out_data = word_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         tag_q <= 1'b0;
      end else if (in_rdy) begin
         tag_q <= in_vld;
      end
   end

   always_ff @(posedge clk) begin
      if (in_vld && in_rdy) begin
         word_q <= in_data;
      end
   end

   // R5: an unaccepted word stays put
   p_hold_word_r5: assert property (@(posedge clk) disable iff (rst)
      (tag_q && !out_rdy) |=> (tag_q && $stable(word_q)));

   // R6: an accepted offer is presented on the next cycle
   p_take_word_r6: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_rdy) |=> out_vld);

endmodule

// File: rtl/stream_fifo.sv
module stream_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_vld,
   output logic              in_rdy,
   output logic [DATA_W-1:0] out_data,
   output logic              out_vld,
   input  logic              out_rdy
);

   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [DATA_W-1:0] store [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr;
   logic [CW-1:0]     fill;
   logic              push, pop;

   assign in_rdy   = (fill != FULL_CNT);
   assign out_vld  = (fill != '0);
   assign out_data = store[rd_ptr];
   assign push     = in_vld && in_rdy;
   assign pop      = out_vld && out_rdy;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         store[wr_ptr] <= in_data;
      end
   end

   // R3: a full queue with no read stays closed to the writer
   p_full_stays_r3: assert property (@(posedge clk) disable iff (rst)
      (fill == FULL_CNT && !pop) |=> !in_rdy);

   // R4: a written word makes data available on the next cycle
   p_avail_after_push_r4: assert property (@(posedge clk) disable iff (rst)
      push |=> out_vld);

   // R2: a single word alone in the queue is the one read next
   p_single_word_r2: assert property (@(posedge clk) disable iff (rst)
      (push && fill == '0) |=> (out_data == $past(in_data)));

endmodule

// File: rtl/stream_signal.sv
module stream_signal #(
   parameter int SIG_W       = 8,
   parameter bit HAS_PAYLOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             post_req,
   input  logic [SIG_W-1:0] post_data,
   output logic             post_done,
   input  logic             wait_req,
   output logic             wait_done,
   output logic [SIG_W-1:0] wait_data
);

   logic pend_q;

   assign post_done = post_req && !pend_q;
   assign wait_done = wait_req && (pend_q || post_req);

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         if (wait_req) pend_q <= 1'b0;
      end else if (post_req && !wait_req) begin
         pend_q <= 1'b1;
      end
   end

   generate
      if (HAS_PAYLOAD) begin : g_payload
         logic [SIG_W-1:0] held_q;

         always_ff @(posedge clk) begin
            if (post_done && !wait_req) begin
               held_q <= post_data;
            end
         end

         assign wait_data = pend_q ? held_q : post_data;

         // R9: a pending payload is not overwritten
         p_keep_payload_r9: assert property (@(posedge clk) disable iff (rst)
            (pend_q && !wait_req) |=> $stable(held_q));
      end else begin : g_no_payload
         assign wait_data = '0;

         // R10: no payload is ever delivered
         p_zero_payload_r10: assert property (@(posedge clk) disable iff (rst)
            wait_done |-> (wait_data == '0));
      end
   endgenerate

   // R9: a poster is stalled while an event waits
   p_stall_post_r9: assert property (@(posedge clk) disable iff (rst)
      (pend_q && !wait_req) |=> !post_done);

   // R8: a matched post and wait leave nothing behind
   p_pass_through_r8: assert property (@(posedge clk) disable iff (rst)
      (post_req && wait_req && !pend_q) |=> !pend_q);

   // R7: an unmatched post satisfies the next wait
   p_post_waits_r7: assert property (@(posedge clk) disable iff (rst)
      (post_done && !wait_req) |=> (!wait_req || wait_done));

endmodule

// File: rtl/stream_link.sv
module stream_link #(
   parameter int                         DATA_W      = 8,
   parameter int                         DEPTH       = 4,
   parameter stream_link_pkg::link_mode_e MODE       = stream_link_pkg::LINK_FIFO,
   parameter int                         SIG_W       = 8,
   parameter bit                         HAS_PAYLOAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_valid,
   output logic              wr_ready,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_avail,
   input  logic              rd_ready,
   input  logic              post_req,
   input  logic [SIG_W-1:0]  post_data,
   output logic              post_done,
   input  logic              wait_req,
   output logic              wait_done,
   output logic [SIG_W-1:0]  wait_data
);

   generate
      if (DATA_W < 1) begin : g_bad_data_w
         $error("stream_link: DATA_W must be at least 1");
      end
      if (SIG_W < 1) begin : g_bad_sig_w
         $error("stream_link: SIG_W must be at least 1");
      end
   endgenerate

   generate
      if (MODE == stream_link_pkg::LINK_FIFO) begin : g_queue
         if (DEPTH < 2 || !stream_link_pkg::is_pow2(DEPTH)) begin : g_bad_depth
            $error("stream_link: DEPTH must be a power of two of at least 2");
         end
         stream_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
         ) u_path (
            .clk      (clk),
            .rst      (rst),
            .in_data  (wr_data),
            .in_vld   (wr_valid),
            .in_rdy   (wr_ready),
            .out_data (rd_data),
            .out_vld  (rd_avail),
            .out_rdy  (rd_ready)
         );
      end else begin : g_tag
         stream_tag_slot #(
            .DATA_W (DATA_W)
         ) u_path (
            .clk      (clk),
            .rst      (rst),
            .in_data  (wr_data),
            .in_vld   (wr_valid),
            .in_rdy   (wr_ready),
            .out_data (rd_data),
            .out_vld  (rd_avail),
            .out_rdy  (rd_ready)
         );
      end
   endgenerate

   stream_signal #(
      .SIG_W       (SIG_W),
      .HAS_PAYLOAD (HAS_PAYLOAD)
   ) u_signal (
      .clk       (clk),
      .rst       (rst),
      .post_req  (post_req),
      .post_data (post_data),
      .post_done (post_done),
      .wait_req  (wait_req),
      .wait_done (wait_done),
      .wait_data (wait_data)
   );

   // R1: the cycle after reset shows an empty link
   p_reset_empty_r1: assert property (@(posedge clk)
      $past(rst) |-> (!rd_avail && wr_ready));

endmodule

// File: tb/stream_link_test.sv
`timescale 1ns/1ps
module stream_link_test;

   localparam int W = 8;

   int checks = 0;
   int errors = 0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;

   // queue-mode instance signals
   logic [W-1:0] f_wr_data = '0, f_rd_data, f_post_data = '0, f_wait_data;
   logic f_wr_valid = 0, f_wr_ready, f_rd_avail, f_rd_ready = 0;
   logic f_post_req = 0, f_post_done, f_wait_req = 0, f_wait_done;
   // tag-mode instance signals
   logic [W-1:0] t_wr_data = '0, t_rd_data, t_post_data = '0, t_wait_data;
   logic t_wr_valid = 0, t_wr_ready, t_rd_avail, t_rd_ready = 0;
   logic t_post_req = 0, t_post_done, t_wait_req = 0, t_wait_done;

   stream_link #(.DATA_W(W), .DEPTH(4), .MODE(stream_link_pkg::LINK_FIFO),
                 .SIG_W(W), .HAS_PAYLOAD(1'b1)) uut (
      .clk(clk), .rst(rst),
      .wr_data(f_wr_data), .wr_valid(f_wr_valid), .wr_ready(f_wr_ready),
      .rd_data(f_rd_data), .rd_avail(f_rd_avail), .rd_ready(f_rd_ready),
      .post_req(f_post_req), .post_data(f_post_data), .post_done(f_post_done),
      .wait_req(f_wait_req), .wait_done(f_wait_done), .wait_data(f_wait_data));

   stream_link #(.DATA_W(W), .DEPTH(4), .MODE(stream_link_pkg::LINK_TAG),
                 .SIG_W(W), .HAS_PAYLOAD(1'b0)) uut_tag (
      .clk(clk), .rst(rst),
      .wr_data(t_wr_data), .wr_valid(t_wr_valid), .wr_ready(t_wr_ready),
      .rd_data(t_rd_data), .rd_avail(t_rd_avail), .rd_ready(t_rd_ready),
      .post_req(t_post_req), .post_data(t_post_data), .post_done(t_post_done),
      .wait_req(t_wait_req), .wait_done(t_wait_done), .wait_data(t_wait_data));

   logic [W-1:0] fq[$];
   logic [W-1:0] tq[$];
   bit f_on = 0, t_on = 0, f_acc = 0, t_acc = 0, tog = 0;
   bit t_hold = 0;
   logic [W-1:0] t_hold_data = '0;
   logic [W-1:0] f_next = 8'h10, t_next = 8'h80;
   logic [15:0] lfsr = 16'hACE1;
   int cons = 0;
   int f_pushes = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #5;
   endtask

   // producers and consumer ready patterns, driven just after the falling edge
   always @(negedge clk) begin
      logic r;
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tog  = ~tog;
      if (f_acc) f_next = f_next + 1'b1;
      if (t_acc) t_next = t_next + 1'b1;
      f_acc = 0;
      t_acc = 0;
      f_wr_valid = f_on;
      f_wr_data  = f_next;
      t_wr_valid = t_on;
      t_wr_data  = t_next;
      case (cons)
         1:       r = 1'b1;
         2:       r = tog;
         3:       r = lfsr[0];
         default: r = 1'b0;
      endcase
      f_rd_ready = r;
      t_rd_ready = (cons == 3) ? lfsr[3] : r;
   end

   // monitor: handshakes sampled 2 ns before the rising edge
   always @(negedge clk) begin
      #8;
      if (rst) begin
         fq.delete();
         tq.delete();
         t_hold = 0;
      end else begin
         if (f_wr_valid && f_wr_ready) begin
            fq.push_back(f_wr_data);
            f_acc = 1;
            f_pushes++;
         end
         if (f_rd_avail && f_rd_ready) begin
            if (fq.size() == 0) chk("R2", "queue word with none expected", 1, 0);
            else chk("R2", "queue word order", int'(f_rd_data), int'(fq.pop_front()));
         end
         chk("R6", "tag wr_ready", int'(t_wr_ready), int'(!t_rd_avail || t_rd_ready));
         if (t_hold) begin
            chk("R5", "tag avail held", int'(t_rd_avail), 1);
            chk("R5", "tag data held", int'(t_rd_data), int'(t_hold_data));
         end
         t_hold      = t_rd_avail && !t_rd_ready;
         t_hold_data = t_rd_data;
         if (t_wr_valid && t_wr_ready) begin
            tq.push_back(t_wr_data);
            t_acc = 1;
         end
         if (t_rd_avail && t_rd_ready) begin
            if (tq.size() == 0) chk("R2", "tag word with none expected", 1, 0);
            else chk("R2", "tag word order", int'(t_rd_data), int'(tq.pop_front()));
         end
      end
   end

   initial begin
      #(20 * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      step(3);
      rst = 0;
      step(1);
      // R1 reset state
      chk("R1", "queue rd_avail", int'(f_rd_avail), 0);
      chk("R1", "queue wr_ready", int'(f_wr_ready), 1);
      chk("R1", "tag rd_avail", int'(t_rd_avail), 0);
      f_wait_req = 1;
      #1 chk("R1", "wait with nothing pending", int'(f_wait_done), 0);
      f_wait_req = 0;

      // R4 latency of a single word
      f_on = 1;
      step(1);
      chk("R4", "avail before write edge", int'(f_rd_avail), 0);
      f_on = 0;
      step(1);
      chk("R4", "avail after write edge", int'(f_rd_avail), 1);
      chk("R4", "data after write edge", int'(f_rd_data), int'(fq[0]));

      // R3 fill to depth
      f_on = 1;
      step(8);
      chk("R3", "wr_ready when full", int'(f_wr_ready), 0);
      chk("R3", "words held when full", fq.size(), 4);
      f_on = 0;
      cons = 1;
      step(8);
      chk("R2", "queue drained", fq.size(), 0);
      chk("R4", "avail when empty", int'(f_rd_avail), 0);

      // R2 R5 R6 streaming under mixed consumer patterns
      f_on = 1;
      t_on = 1;
      cons = 3;
      step(300);
      cons = 2;
      step(100);
      f_on = 0;
      t_on = 0;
      cons = 1;
      step(10);
      chk("R2", "queue words all delivered", fq.size(), 0);
      chk("R2", "tag words all delivered", tq.size(), 0);
      chk("R2", "queue made progress", int'(f_pushes > 150), 1);
      cons = 0;

      // R7 R9 R8 event path
      f_post_req  = 1;
      f_post_data = 8'h5A;
      #1;
      chk("R7", "post accepted", int'(f_post_done), 1);
      chk("R7", "no wait done without wait", int'(f_wait_done), 0);
      step(1);
      f_post_data = 8'h33;
      #1 chk("R9", "second post stalled", int'(f_post_done), 0);
      step(1);
      #1 chk("R9", "second post still stalled", int'(f_post_done), 0);
      f_post_req = 0;
      f_wait_req = 1;
      #1;
      chk("R7", "wait takes pending event", int'(f_wait_done), 1);
      chk("R9", "pending payload kept", int'(f_wait_data), 8'h5A);
      step(1);
      #1 chk("R7", "event consumed", int'(f_wait_done), 0);
      f_post_req  = 1;
      f_post_data = 8'hC3;
      #1;
      chk("R8", "post done when matched", int'(f_post_done), 1);
      chk("R8", "wait done when matched", int'(f_wait_done), 1);
      chk("R8", "payload passed through", int'(f_wait_data), 8'hC3);
      step(1);
      f_post_req = 0;
      #1 chk("R8", "nothing left pending", int'(f_wait_done), 0);
      f_wait_req = 0;

      // R10 no payload on the tag instance
      t_post_req  = 1;
      t_post_data = 8'hFF;
      t_wait_req  = 1;
      #1;
      chk("R10", "matched wait done", int'(t_wait_done), 1);
      chk("R10", "matched data zero", int'(t_wait_data), 0);
      t_wait_req = 0;
      step(1);
      t_post_req = 0;
      t_wait_req = 1;
      #1;
      chk("R10", "pending wait done", int'(t_wait_done), 1);
      chk("R10", "pending data zero", int'(t_wait_data), 0);
      step(1);
      t_wait_req = 0;

      // R1 reset in mid-operation
      f_on = 1;
      t_on = 1;
      f_post_req  = 1;
      f_post_data = 8'h77;
      step(3);
      f_on = 0;
      t_on = 0;
      f_post_req = 0;
      rst = 1;
      step(1);
      rst = 0;
      step(1);
      chk("R1", "queue empty after reset", int'(f_rd_avail), 0);
      chk("R1", "queue ready after reset", int'(f_wr_ready), 1);
      chk("R1", "tag empty after reset", int'(t_rd_avail), 0);
      f_wait_req = 1;
      #1 chk("R1", "pending event cleared", int'(f_wait_done), 0);
      f_wait_req = 0;
      step(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule